// File: doc/BRIEF.md
# Interrupt Acknowledge Slice with Spurious Vector

This block is one slice of a local interrupt controller. It keeps a task-priority value and a spurious-vector control word. It watches a single pending vector and asks the processor for service on an interrupt request line. The request is raised only when the vector's priority class, its upper four bits, is above the class of the task priority and the controller is enabled by software.

When the processor acknowledges, the block checks the mask again against the current register contents. If the request is still unmasked, the block returns the pending vector and pulses an in-service set strobe. If it has become masked, the block returns the programmable spurious vector and leaves in-service state untouched. Masking includes a raised task priority, a disabled controller, or a withdrawn request. The task priority can be written in full through the register port, or through a narrow alias port that carries only its class nibble. An end-of-interrupt input requests a broadcast for level-triggered sources unless software has suppressed it.

Top module: `irq_ack_slice`

## Requirements
- R1: After reset, `intr`, `ack_valid`, `isr_set` and `eoi_bcast` are 0 and `ack_vec` is 0. The control word reads 0x0000_00FF: vector all ones, every other field clear. The task priority reads 0.
- R2: The control word is selected when `reg_sel`=0. A write stores vector bits [7:0], software enable at bit 8 (1 = enabled), focus-check control at bit 9 (0 = checking on) and broadcast suppression at bit 12. A read returns those fields, and every other bit reads 0.
- R3: With `LOW_HARDWIRED`=1, only vector bits [7:4] are writable. Bits [3:0] read as ones, in the control word and in any returned spurious vector, whatever was written to them.
- R4: A write on the alias port sets task priority [7:4] to `cr_wdata` and clears [3:0]. `cr_rdata` returns task priority [7:4] zero-extended to 64 bits. If the alias port and the register port write the task priority in the same cycle, the alias value is kept.
- R5: `intr` is 1 in the cycle after one in which `pend_valid`=1, software enable=1, `pend_vec`[7:4] is strictly greater than task priority [7:4], and `inta`=0. Otherwise it is 0 in that cycle.
- R6: In the cycle after `inta`=1 with the request unmasked, `ack_valid`=1, `ack_vec` equals `pend_vec` and `isr_set`=1, each for one cycle. `intr` is 0 in that cycle. `ack_vec` is 0 whenever `ack_valid`=0.
- R7: In the cycle after `inta`=1 with the request masked (no pending vector, class not above task priority, or software enable 0), `ack_valid`=1, `ack_vec` equals the spurious vector, and `isr_set`=0.
- R8: The mask check on an acknowledge uses the register values held before the edge that samples `inta`. A task-priority or control-word write in the same cycle does not affect that acknowledge.
- R9: In the cycle after `eoi`=1 with `eoi_level`=1 and suppression bit 0, `eoi_bcast`=1. It is 0 after an edge-type EOI, while suppression is 1, and when no EOI occurs.
- R10: The task priority is selected when `reg_sel`=1. A write stores `reg_wdata`[7:0] when the alias port is idle. A read returns it in bits [7:0], with all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = task priority |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| cr_wr | input | 1 | Alias-port write strobe |
| cr_wdata | input | 4 | Alias-port priority class |
| cr_rdata | output | 64 | Alias-port read data |
| pend_valid | input | 1 | Pending vector present |
| pend_vec | input | 8 | Pending vector |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge from the processor |
| ack_valid | output | 1 | Returned vector valid |
| ack_vec | output | 8 | Returned vector |
| isr_set | output | 1 | In-service set strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_level | input | 1 | EOI is for a level-triggered source |
| eoi_bcast | output | 1 | Broadcast request |

## Verification
The case that matters is an acknowledge that lands in the same cycle as a write that masks or unmasks the pending vector. Two such writes are an alias-port priority raise and a register write that clears the enable bit. The bench provokes this with a directed step that raises `inta` and the alias write together. It also runs a long random phase in which acknowledges, both write paths and EOIs overlap freely. Each cycle is judged against a behavioural model that evaluates the mask from the register values before the edge and applies the writes after it. So a vector acknowledged in a masking cycle must still come back as the real vector with the in-service strobe. A second instance with the hardwired low nibble runs on the same stimulus.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   // field positions of the control word
   localparam int unsigned EN_BIT    = 8;
   localparam int unsigned FOCUS_BIT = 9;
   localparam int unsigned SUP_BIT   = 12;
   localparam int unsigned CTRL_MIN_W = SUP_BIT + 1;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_PRIO = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_ctrl_word.sv
module irq_ctrl_word
   import irq_ack_pkg::*;
#(
   parameter int unsigned VEC_W         = 8,
   parameter int unsigned CLASS_W       = 4,
   parameter int unsigned REG_W         = 32,
   parameter bit          LOW_HARDWIRED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [VEC_W-1:0] wr_vec,
   input  logic             wr_en,
   input  logic             wr_focus,
   input  logic             wr_sup,
   output logic [VEC_W-1:0] spur_vec,
   output logic             sw_en,
   output logic             sup,
   output logic [REG_W-1:0] rdata
);
   localparam int unsigned LOW_W = VEC_W - CLASS_W;

   logic en_q, focus_q, sup_q;

   generate
      if (LOW_HARDWIRED) begin : g_hw_low
         logic [CLASS_W-1:0] hi_q;
         logic               unused_low;
         assign unused_low = ^wr_vec[LOW_W-1:0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  hi_q <= '1;
            else if (wr) hi_q <= wr_vec[VEC_W-1 -: CLASS_W];
         end
         assign spur_vec = {hi_q, {LOW_W{1'b1}}};
      end else begin : g_full
         logic [VEC_W-1:0] vec_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  vec_q <= '1;
            else if (wr) vec_q <= wr_vec;
         end
         assign spur_vec = vec_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         focus_q <= 1'b0;
         sup_q   <= 1'b0;
      end else if (wr) begin
         en_q    <= wr_en;
         focus_q <= wr_focus;
         sup_q   <= wr_sup;
      end
   end

   assign sw_en = en_q;
   assign sup   = sup_q;

   always_comb begin
      rdata            = '0;
      rdata[VEC_W-1:0] = spur_vec;
      rdata[EN_BIT]    = en_q;
      rdata[FOCUS_BIT] = focus_q;
      rdata[SUP_BIT]   = sup_q;
   end
endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg #(
   parameter int unsigned VEC_W      = 8,
   parameter int unsigned CLASS_W    = 4,
   parameter int unsigned REG_W      = 32,
   parameter int unsigned ALIAS_RD_W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [VEC_W-1:0]      wdata,
   input  logic                  cr_wr,
   input  logic [CLASS_W-1:0]    cr_wdata,
   output logic [VEC_W-1:0]      prio,
   output logic [REG_W-1:0]      rdata,
   output logic [ALIAS_RD_W-1:0] cr_rdata
);
   localparam int unsigned LOW_W = VEC_W - CLASS_W;

   logic [VEC_W-1:0] prio_q;

   // alias path has precedence over the full-width write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prio_q <= '0;
      else if (cr_wr) prio_q <= {cr_wdata, {LOW_W{1'b0}}};
      else if (wr)    prio_q <= wdata;
   end

   assign prio     = prio_q;
   assign rdata    = {{(REG_W-VEC_W){1'b0}}, prio_q};
   assign cr_rdata = {{(ALIAS_RD_W-CLASS_W){1'b0}}, prio_q[VEC_W-1 -: CLASS_W]};
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned CLASS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_en,
   input  logic             sup,
   input  logic [VEC_W-1:0] prio,
   input  logic [VEC_W-1:0] spur_vec,
   input  logic             pend_valid,
   input  logic [VEC_W-1:0] pend_vec,
   input  logic             inta,
   input  logic             eoi,
   input  logic             eoi_level,
   output logic             intr,
   output logic             ack_valid,
   output logic [VEC_W-1:0] ack_vec,
   output logic             isr_set,
   output logic             eoi_bcast
);
   logic [CLASS_W-1:0] pend_class, prio_class;
   logic               unmasked;
   logic               intr_q, ackv_q, isr_q, bcast_q;
   logic [VEC_W-1:0]   ackvec_q;

   assign pend_class = pend_vec[VEC_W-1 -: CLASS_W];
   assign prio_class = prio[VEC_W-1 -: CLASS_W];
   assign unmasked   = pend_valid & sw_en & (pend_class > prio_class);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intr_q   <= 1'b0;
         ackv_q   <= 1'b0;
         isr_q    <= 1'b0;
         ackvec_q <= '0;
         bcast_q  <= 1'b0;
      end else begin
         intr_q   <= unmasked & ~inta;
         ackv_q   <= inta;
         isr_q    <= inta & unmasked;
         ackvec_q <= !inta ? '0 : (unmasked ? pend_vec : spur_vec);
         bcast_q  <= eoi & eoi_level & ~sup;
      end
   end

   assign intr      = intr_q;
   assign ack_valid = ackv_q;
   assign isr_set   = isr_q;
   assign ack_vec   = ackvec_q;
   assign eoi_bcast = bcast_q;
endmodule

// File: rtl/irq_ack_slice.sv
module irq_ack_slice
   import irq_ack_pkg::*;
#(
   parameter int unsigned VEC_W         = 8,
   parameter int unsigned CLASS_W       = 4,
   parameter int unsigned REG_W         = 32,
   parameter int unsigned ALIAS_RD_W    = 64,
   parameter bit          LOW_HARDWIRED = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_sel,
   input  logic [REG_W-1:0]      reg_wdata,
   output logic [REG_W-1:0]      reg_rdata,
   input  logic                  cr_wr,
   input  logic [CLASS_W-1:0]    cr_wdata,
   output logic [ALIAS_RD_W-1:0] cr_rdata,
   input  logic                  pend_valid,
   input  logic [VEC_W-1:0]      pend_vec,
   output logic                  intr,
   input  logic                  inta,
   output logic                  ack_valid,
   output logic [VEC_W-1:0]      ack_vec,
   output logic                  isr_set,
   input  logic                  eoi,
   input  logic                  eoi_level,
   output logic                  eoi_bcast
);
   generate
      if (CLASS_W == 0 || CLASS_W >= VEC_W) begin : g_bad_class
         $error("irq_ack_slice: CLASS_W must lie between 1 and VEC_W-1");
      end
      if (REG_W < CTRL_MIN_W || REG_W < VEC_W) begin : g_bad_reg
         $error("irq_ack_slice: REG_W too narrow for the control word");
      end
      if (ALIAS_RD_W < CLASS_W) begin : g_bad_alias
         $error("irq_ack_slice: ALIAS_RD_W narrower than CLASS_W");
      end
      if (VEC_W > EN_BIT) begin : g_bad_vec
         $error("irq_ack_slice: VEC_W overlaps the enable field");
      end
   endgenerate

   logic             ctrl_wr, prio_wr;
   logic [VEC_W-1:0] spur_vec, prio;
   logic             sw_en, sup;
   logic [REG_W-1:0] ctrl_rdata, prio_rdata;
   logic             unused_wbits;

   assign ctrl_wr      = reg_wr & (reg_sel == SEL_CTRL);
   assign prio_wr      = reg_wr & (reg_sel == SEL_PRIO);
   assign unused_wbits = ^{reg_wdata[REG_W-1:SUP_BIT+1], reg_wdata[SUP_BIT-1:FOCUS_BIT+1],
                           reg_wdata[EN_BIT-1:VEC_W]};

   irq_ctrl_word #(
      .VEC_W(VEC_W), .CLASS_W(CLASS_W), .REG_W(REG_W), .LOW_HARDWIRED(LOW_HARDWIRED)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wr_vec   (reg_wdata[VEC_W-1:0]),
      .wr_en    (reg_wdata[EN_BIT]),
      .wr_focus (reg_wdata[FOCUS_BIT]),
      .wr_sup   (reg_wdata[SUP_BIT]),
      .spur_vec (spur_vec),
      .sw_en    (sw_en),
      .sup      (sup),
      .rdata    (ctrl_rdata)
   );

   irq_prio_reg #(
      .VEC_W(VEC_W), .CLASS_W(CLASS_W), .REG_W(REG_W), .ALIAS_RD_W(ALIAS_RD_W)
   ) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (prio_wr),
      .wdata    (reg_wdata[VEC_W-1:0]),
      .cr_wr    (cr_wr),
      .cr_wdata (cr_wdata),
      .prio     (prio),
      .rdata    (prio_rdata),
      .cr_rdata (cr_rdata)
   );

   irq_ack_ctrl #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_en      (sw_en),
      .sup        (sup),
      .prio       (prio),
      .spur_vec   (spur_vec),
      .pend_valid (pend_valid),
      .pend_vec   (pend_vec),
      .inta       (inta),
      .eoi        (eoi),
      .eoi_level  (eoi_level),
      .intr       (intr),
      .ack_valid  (ack_valid),
      .ack_vec    (ack_vec),
      .isr_set    (isr_set),
      .eoi_bcast  (eoi_bcast)
   );

   assign reg_rdata = (reg_sel == SEL_PRIO) ? prio_rdata : ctrl_rdata;
endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
   parameter int unsigned VEC_W         = 8,
   parameter int unsigned CLASS_W       = 4,
   parameter int unsigned REG_W         = 32,
   parameter int unsigned ALIAS_RD_W    = 64,
   parameter bit          LOW_HARDWIRED = 1'b0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_sel,
   input logic [REG_W-1:0]      reg_rdata,
   input logic                  cr_wr,
   input logic [CLASS_W-1:0]    cr_wdata,
   input logic [ALIAS_RD_W-1:0] cr_rdata,
   input logic                  pend_valid,
   input logic                  intr,
   input logic                  inta,
   input logic                  ack_valid,
   input logic [VEC_W-1:0]      ack_vec,
   input logic                  isr_set,
   input logic                  eoi,
   input logic                  eoi_level,
   input logic                  eoi_bcast
);
   localparam int unsigned LOW_W = VEC_W - CLASS_W;

   assert_alias_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cr_wr |=> (cr_rdata[CLASS_W-1:0] == $past(cr_wdata)) &&
                (cr_rdata[ALIAS_RD_W-1:CLASS_W] == '0));

   assert_intr_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> $past(pend_valid));

   assert_ack_after_inta_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> ack_valid && !intr);

   assert_ack_only_after_inta_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(inta));

   assert_isr_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      isr_set |-> ack_valid);

   assert_idle_vec_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_valid |-> ack_vec == '0);

   assert_bcast_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast |-> $past(eoi && eoi_level));

   generate
      if (LOW_HARDWIRED) begin : g_hw
         assert_low_ones_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_sel == 1'b0) |-> reg_rdata[LOW_W-1:0] == {LOW_W{1'b1}});
         assert_low_ones_spur_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && !isr_set) |-> ack_vec[LOW_W-1:0] == {LOW_W{1'b1}});
      end
   endgenerate
endmodule

bind irq_ack_slice irq_ack_checker #(
   .VEC_W(VEC_W), .CLASS_W(CLASS_W), .REG_W(REG_W),
   .ALIAS_RD_W(ALIAS_RD_W), .LOW_HARDWIRED(LOW_HARDWIRED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_sel    (reg_sel),
   .reg_rdata  (reg_rdata),
   .cr_wr      (cr_wr),
   .cr_wdata   (cr_wdata),
   .cr_rdata   (cr_rdata),
   .pend_valid (pend_valid),
   .intr       (intr),
   .inta       (inta),
   .ack_valid  (ack_valid),
   .ack_vec    (ack_vec),
   .isr_set    (isr_set),
   .eoi        (eoi),
   .eoi_level  (eoi_level),
   .eoi_bcast  (eoi_bcast)
);

// File: tb/sim_irq_ack_slice.sv
module sim_irq_ack_slice;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        cr_wr = 1'b0;
   logic [3:0]  cr_wdata = '0;
   logic        pend_valid = 1'b0;
   logic [7:0]  pend_vec = '0;
   logic        inta = 1'b0, eoi = 1'b0, eoi_level = 1'b0;

   logic [31:0] reg_rdata, u1_reg_rdata;
   logic [63:0] cr_rdata, u1_cr_rdata;
   logic        intr, ack_valid, isr_set, eoi_bcast;
   logic        u1_intr, u1_ack_valid, u1_isr_set, u1_eoi_bcast;
   logic [7:0]  ack_vec, u1_ack_vec;

   int checks = 0, fails = 0, cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ack_slice u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cr_wr(cr_wr),
      .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .pend_valid(pend_valid),
      .pend_vec(pend_vec), .intr(intr), .inta(inta), .ack_valid(ack_valid),
      .ack_vec(ack_vec), .isr_set(isr_set), .eoi(eoi), .eoi_level(eoi_level),
      .eoi_bcast(eoi_bcast));

   irq_ack_slice #(.LOW_HARDWIRED(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(u1_reg_rdata), .cr_wr(cr_wr),
      .cr_wdata(cr_wdata), .cr_rdata(u1_cr_rdata), .pend_valid(pend_valid),
      .pend_vec(pend_vec), .intr(u1_intr), .inta(inta), .ack_valid(u1_ack_valid),
      .ack_vec(u1_ack_vec), .isr_set(u1_isr_set), .eoi(eoi), .eoi_level(eoi_level),
      .eoi_bcast(u1_eoi_bcast));

   // behavioural reference model
   logic [7:0] m_vec = 8'hFF, m_tpr = 8'h00, m_ackvec = 8'h00;
   bit m_en = 0, m_focus = 0, m_sup = 0, m_intr = 0, m_ackv = 0, m_isr = 0;
   bit m_bcast = 0, m_spur = 0;

   function automatic bit model_unmasked();
      return pend_valid && m_en && (int'(pend_vec[7:4]) > int'(m_tpr[7:4]));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_vec <= 8'hFF; m_tpr <= 8'h00; m_en <= 0; m_focus <= 0; m_sup <= 0;
         m_intr <= 0; m_ackv <= 0; m_isr <= 0; m_ackvec <= 8'h00;
         m_bcast <= 0; m_spur <= 0;
      end else begin
         m_intr   <= model_unmasked() && !inta;
         m_ackv   <= inta;
         m_isr    <= inta && model_unmasked();
         m_spur   <= inta && !model_unmasked();
         m_ackvec <= !inta ? 8'h00 : (model_unmasked() ? pend_vec : m_vec);
         m_bcast  <= eoi && eoi_level && !m_sup;
         if (reg_wr && !reg_sel) begin
            m_vec <= reg_wdata[7:0]; m_en <= reg_wdata[8];
            m_focus <= reg_wdata[9]; m_sup <= reg_wdata[12];
         end
         if (cr_wr) m_tpr <= {cr_wdata, 4'h0};
         else if (reg_wr && reg_sel) m_tpr <= reg_wdata[7:0];
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (!done) begin
         logic [31:0] ctrl_exp;
         logic [7:0]  u1_ack_exp;
         ctrl_exp = {19'b0, m_sup, 2'b00, m_focus, m_en, m_vec};
         u1_ack_exp = m_spur ? (m_ackvec | 8'h0F) : m_ackvec;
         if (!rst_n) begin
            chk("R1 intr", intr, 0);
            chk("R1 ack_valid", ack_valid, 0);
            chk("R1 ack_vec", ack_vec, 0);
            chk("R1 isr_set", isr_set, 0);
            chk("R1 eoi_bcast", eoi_bcast, 0);
            chk("R1 reg_rdata", reg_rdata, reg_sel ? 32'h0 : 32'h0000_00FF);
         end else begin
            if (!reg_sel) begin
               chk("R2 control word read", reg_rdata, ctrl_exp);
               chk("R3 hardwired control read", u1_reg_rdata, ctrl_exp | 32'h0F);
            end else begin
               chk("R10 priority read", reg_rdata, {24'h0, m_tpr});
               chk("R10 priority read u1", u1_reg_rdata, {24'h0, m_tpr});
            end
            chk("R4 alias read", cr_rdata, {60'h0, m_tpr[7:4]});
            chk("R5 intr", intr, m_intr);
            chk("R5 intr u1", u1_intr, m_intr);
            chk("R6 ack_valid", ack_valid, m_ackv);
            chk("R6 isr_set", isr_set, m_isr);
            chk("R6 isr_set u1", u1_isr_set, m_isr);
            chk(m_spur ? "R7 spurious ack_vec" : "R6 ack_vec", ack_vec, m_ackvec);
            chk("R3 hardwired ack_vec", u1_ack_vec, u1_ack_exp);
            chk("R9 eoi_bcast", eoi_bcast, m_bcast);
            chk("R9 eoi_bcast u1", u1_eoi_bcast, m_bcast);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         checks++; fails++;
         $display("FAIL watchdog R1 act=%0d exp<=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic quiet();
      reg_wr = 0; cr_wr = 0; inta = 0; eoi = 0;
   endtask

   task automatic wr_reg(input logic sel, input logic [31:0] d);
      reg_wr = 1; reg_sel = sel; reg_wdata = d; tick(); quiet();
   endtask

   task automatic wr_alias(input logic [3:0] d);
      cr_wr = 1; cr_wdata = d; tick(); quiet();
   endtask

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      reg_sel = 1; tick();                      // R1 priority reads 0
      reg_sel = 0;
      // R2: all-ones pattern, only defined fields survive
      wr_reg(0, 32'hFFFF_F3A5); tick();
      chk("R2 control word fields", reg_rdata, 32'h0000_13A5);
      chk("R3 low nibble ones", u1_reg_rdata, 32'h0000_13AF);
      // R2: clear focus and suppression, keep enable
      wr_reg(0, 32'h0000_01A5); tick();
      // R4: alias write
      wr_alias(4'h3); reg_sel = 1; tick();
      chk("R4 alias sets class and clears low bits", reg_rdata, 32'h30);
      chk("R4 zero-extended alias read", cr_rdata, 64'h3);
      // R5/R6: unmasked vector
      pend_valid = 1; pend_vec = 8'h52; tick(); tick();
      chk("R5 intr raised", intr, 1);
      inta = 1; tick(); quiet(); pend_valid = 0;
      #1 chk("R6 returned vector", ack_vec, 8'h52);
      chk("R6 in-service strobe", isr_set, 1);
      chk("R6 intr drops", intr, 0);
      tick();
      // R7: equal class is masked
      pend_valid = 1; pend_vec = 8'h35; tick(); tick();
      chk("R5 equal class no intr", intr, 0);
      inta = 1; tick(); quiet(); pend_valid = 0;
      chk("R7 spurious on equal class", ack_vec, 8'hA5);
      chk("R7 no in-service", isr_set, 0);
      chk("R3 hardwired spurious", u1_ack_vec, 8'hAF);
      tick();
      // R7: masked after INTR raised
      pend_valid = 1; pend_vec = 8'h72; tick(); tick();
      chk("R5 intr for 0x72", intr, 1);
      wr_alias(4'h8);
      inta = 1; tick(); quiet(); pend_valid = 0;
      chk("R7 masked before ack", ack_vec, 8'hA5);
      chk("R7 masked no isr", isr_set, 0);
      tick();
      // R8: masking write in the same cycle as INTA
      pend_valid = 1; pend_vec = 8'h92; tick(); tick();
      inta = 1; cr_wr = 1; cr_wdata = 4'hF; tick(); quiet(); pend_valid = 0;
      chk("R8 ack uses pre-write priority", ack_vec, 8'h92);
      chk("R8 isr set despite same-cycle mask", isr_set, 1);
      tick();
      // R4: both write paths together, alias wins
      reg_wr = 1; reg_sel = 1; reg_wdata = 32'h0000_0011; cr_wr = 1; cr_wdata = 4'h2;
      tick(); quiet(); tick();
      chk("R4 alias precedence", reg_rdata, 32'h20);
      wr_reg(1, 32'hFFFF_FF47); tick();
      chk("R10 full priority write", reg_rdata, 32'h47);
      reg_sel = 0;
      // R7: disabled controller
      wr_reg(0, 32'h0000_00C3);
      pend_valid = 1; pend_vec = 8'hE0; tick(); tick();
      chk("R5 disabled holds intr low", intr, 0);
      inta = 1; tick(); quiet(); pend_valid = 0;
      chk("R7 disabled spurious", ack_vec, 8'hC3);
      // R7: no pending vector
      wr_reg(0, 32'h0000_01C3);
      inta = 1; tick(); quiet();
      chk("R7 empty ack spurious", ack_vec, 8'hC3);
      // R9: EOI cases
      eoi = 1; eoi_level = 1; tick(); quiet();
      chk("R9 level EOI broadcasts", eoi_bcast, 1);
      eoi = 1; eoi_level = 0; tick(); quiet();
      chk("R9 edge EOI silent", eoi_bcast, 0);
      wr_reg(0, 32'h0000_11C3);
      eoi = 1; eoi_level = 1; tick(); quiet();
      chk("R9 suppressed EOI silent", eoi_bcast, 0);
      // random phase: all functions overlap
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pend_valid = lfsr[0] | lfsr[5];
         pend_vec   = {lfsr[9:6], lfsr[3:0]};
         inta       = (lfsr[11:10] == 2'b11);
         cr_wr      = (lfsr[14:12] == 3'b101);
         cr_wdata   = lfsr[7:4];
         reg_wr     = (lfsr[15:13] == 3'b011);
         reg_sel    = lfsr[2];
         reg_wdata  = {16'h0, 3'b000, lfsr[1], 2'b00, 1'b0, ~lfsr[3] | lfsr[8], lfsr[15:8]};
         eoi        = lfsr[4];
         eoi_level  = lfsr[9];
         tick();
      end
      quiet(); pend_valid = 0;
      repeat (3) tick();
      finish_run();
   end
endmodule